// File: doc/BRIEF.md
# Two-Speed Branch Prediction Fetch Controller

This block steers instruction fetch when two branch predictors of different speed work side by side. A quick predictor answers within the cycle for the current fetch address. Its answer picks the next fetch address at once, so a new fetch group starts every cycle. A slower and more accurate predictor looks at the same group and gives its verdict two cycles later, when the group reaches the last stage and is written into the fetch queue.

Each group in flight carries its address and the quick predictor's taken bit and target, so the last stage can compare the two verdicts directly. When they agree, or the slow predictor has no answer, the group is queued as predicted. When they disagree, the group is queued with the slow verdict. The two younger groups are discarded and fetch restarts at the address the slow predictor chose. A redirect from branch resolution beats an override and empties every stage. A full fetch queue freezes all three stages together, so each group is compared only once.

Top module: `ovr_fetch_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_addr` equals RESET_ADDR, `fq_push` is 0 and `kill_mask` is 0.
- R2: Without stall, flush or redirect, the next cycle's `fetch_addr` is `fast_target` when `fast_vld` and `fast_taken` are both 1, and otherwise `fetch_addr` + GROUP_BYTES.
- R3: A group fetched in cycle t is pushed in cycle t+2. `fq_addr` is its fetch address, `fq_taken` is its final taken bit, and `fq_next` is its target if taken, else its address + GROUP_BYTES.
- R4: When `slow_vld` is 0, or the slow verdict matches the quick one, the group is pushed with the quick prediction, `ovr_flush` is 0 and `kill_mask` is 0.
- R5: On a mismatch the group is pushed with the slow verdict, `ovr_flush` is 1 and `kill_mask` is 3'b011 (bit 0 = fetch stage, bit 1 = cache stage, bit 2 = queue stage). The next `fetch_addr` is that group's `fq_next`, and the two younger groups are never pushed.
- R6: A mismatch is a differing taken bit, or both taken with different targets. Both not taken counts as agreement whatever the targets are.
- R7: `rdr_vld` empties all stages: `kill_mask` is 3'b111, nothing is pushed, `ovr_flush` stays 0 even on a mismatch, and the next `fetch_addr` is `rdr_target`.
- R8: While `fq_full` is 1 and the queue stage holds a group, all stages and `fetch_addr` hold, nothing is pushed, no override fires, and the group is compared once on release.
- R9: `fq_full` with an empty queue stage does not stall fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | output | ADDR_W | Address of the group fetched this cycle |
| fast_vld | input | 1 | Quick predictor has a prediction for `fetch_addr` |
| fast_taken | input | 1 | Quick predictor says taken |
| fast_target | input | ADDR_W | Quick predictor target |
| slow_vld | input | 1 | Slow predictor has a verdict for the queue-stage group |
| slow_taken | input | 1 | Slow predictor says taken |
| slow_target | input | ADDR_W | Slow predictor target |
| rdr_vld | input | 1 | Redirect from branch resolution |
| rdr_target | input | ADDR_W | Redirect address |
| fq_full | input | 1 | Fetch queue cannot accept a group |
| fq_push | output | 1 | Group written into the fetch queue |
| fq_addr | output | ADDR_W | Address of the pushed group |
| fq_taken | output | 1 | Final taken bit of the pushed group |
| fq_next | output | ADDR_W | Address that follows the pushed group |
| ovr_flush | output | 1 | Slow verdict overrode the quick one |
| kill_mask | output | 3 | Stages discarded this cycle |

## Verification
The bench builds the block with ADDR_W = 16, GROUP_BYTES = 16 and RESET_ADDR = 16'h0100. The narrow addresses keep every expected fetch and queue value easy to read in the vector table. The 16-byte step makes sequential addresses land on round hex values, so a taken jump, an override and a fall-through can be told apart at a glance. These values bring within reach a taken-bit override, an override on target alone, agreement on two not-taken verdicts with unequal targets, a two-cycle stall that holds a mismatching verdict, and a redirect that arrives together with a mismatch.

// File: rtl/ovr_fetch_pkg.sv
// Shared types for the two-speed fetch controller.
// Assumes a fixed three-stage front end: fetch, cache access, queue insert.
package ovr_fetch_pkg;
    // Which source, if any, replaces the next fetch address this cycle.
    typedef enum logic [1:0] {
        RD_NONE     = 2'd0,
        RD_OVERRIDE = 2'd1,
        RD_EXTERNAL = 2'd2
    } redir_e;

    localparam int unsigned NUM_STAGES = 3;
    localparam logic [NUM_STAGES-1:0] KILL_NONE  = 3'b000;
    localparam logic [NUM_STAGES-1:0] KILL_YOUNG = 3'b011;
    localparam logic [NUM_STAGES-1:0] KILL_ALL   = 3'b111;
endpackage

// File: rtl/ovr_grp_pipe.sv
// Carries fetch groups from the fetch stage to the queue stage.
// Each slot keeps the fetch address and the quick predictor's taken bit and
// target. A flush empties every slot after the fetch stage; a stall holds them.
// Assumes flush and stall may both be high; flush wins.
module ovr_grp_pipe #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              stall,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_taken,
    input  logic [ADDR_W-1:0] in_target,
    output logic              out_vld,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_taken,
    output logic [ADDR_W-1:0] out_target
);
    logic              vld_q [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic              tk_q  [DEPTH];
    logic [ADDR_W-1:0] tgt_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic              src_vld;
        logic [ADDR_W-1:0] src_addr;
        logic              src_tk;
        logic [ADDR_W-1:0] src_tgt;

        // Select what feeds this slot: the fetch stage or the slot before.
        if (i == 0) begin : g_head
            always_comb begin
                src_vld  = 1'b1;
                src_addr = in_addr;
                src_tk   = in_taken;
                src_tgt  = in_target;
            end
        end else begin : g_body
            always_comb begin
                src_vld  = vld_q[i-1];
                src_addr = addr_q[i-1];
                src_tk   = tk_q[i-1];
                src_tgt  = tgt_q[i-1];
            end
        end

        // Advance, hold or empty this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld_q[i] <= 1'b0;
            end else if (!stall) begin
                vld_q[i] <= src_vld;
            end
        end

        // Payload moves with the slot; no reset needed while invalid.
        always_ff @(posedge clk) begin
            if (!stall) begin
                addr_q[i] <= src_addr;
                tk_q[i]   <= src_tk;
                tgt_q[i]  <= src_tgt;
            end
        end
    end

    assign out_vld    = vld_q[DEPTH-1];
    assign out_addr   = addr_q[DEPTH-1];
    assign out_taken  = tk_q[DEPTH-1];
    assign out_target = tgt_q[DEPTH-1];

    // R8: a stall with no flush leaves the queue-stage slot unchanged.
    a_r8_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> (out_vld == $past(out_vld)) && $stable(out_addr))
        else $error("a_r8_slot_hold");
    // R5: a flush leaves the queue-stage slot empty in the next cycle.
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_vld)
        else $error("a_r5_flush_empties");
endmodule

// File: rtl/ovr_cmp.sv
// Decides whether the slow verdict disagrees with the quick prediction.
// Assumes targets are meaningful only when the matching taken bit is set.
module ovr_cmp #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              fast_taken,
    input  logic [ADDR_W-1:0] fast_target,
    input  logic              slow_taken,
    input  logic [ADDR_W-1:0] slow_target,
    output logic              mismatch
);
    // Direction differs, or both taken toward different places.
    always_comb begin
        mismatch = (fast_taken != slow_taken) ||
                   (fast_taken && slow_taken && (fast_target != slow_target));
    end
endmodule

// File: rtl/ovr_pc_gen.sv
// Holds the fetch address and picks the next one each cycle.
// Priority: external redirect, override, stall, then the quick prediction.
module ovr_pc_gen
    import ovr_fetch_pkg::*;
#(
    parameter int unsigned         ADDR_W      = 32,
    parameter int unsigned         GROUP_BYTES = 16,
    parameter logic [ADDR_W-1:0]   RESET_ADDR  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  redir_e            redir,
    input  logic              stall,
    input  logic [ADDR_W-1:0] ext_target,
    input  logic [ADDR_W-1:0] ovr_target,
    input  logic              fast_taken,
    input  logic [ADDR_W-1:0] fast_target,
    output logic [ADDR_W-1:0] pc
);
    localparam logic [ADDR_W-1:0] GRP_INC = ADDR_W'(GROUP_BYTES);

    logic [ADDR_W-1:0] pc_d;

    // Next-address mux.
    always_comb begin
        unique case (redir)
            RD_EXTERNAL: pc_d = ext_target;
            RD_OVERRIDE: pc_d = ovr_target;
            default: begin
                if (stall)           pc_d = pc;
                else if (fast_taken) pc_d = fast_target;
                else                 pc_d = pc + GRP_INC;
            end
        endcase
    end

    // Fetch address register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_ADDR;
        else        pc <= pc_d;
    end

    // R7: external redirect lands on its target.
    a_r7_ext_target: assert property (@(posedge clk) disable iff (!rst_n)
        (redir == RD_EXTERNAL) |=> pc == $past(ext_target))
        else $error("a_r7_ext_target");
    // R2: undisturbed not-taken fetch steps by one group.
    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (redir == RD_NONE && !stall && !fast_taken) |=> pc == $past(pc) + GRP_INC)
        else $error("a_r2_seq_step");
endmodule

// File: rtl/ovr_fetch_ctrl.sv
// Two-speed prediction fetch controller.
// Stage 1 fetches at pc and follows the quick predictor. Stage 2 is the cache
// access. Stage 3 inserts into the fetch queue and meets the slow verdict.
// Assumes the slow predictor presents its verdict for the stage-3 group and
// keeps it up while the queue is full.
module ovr_fetch_ctrl
    import ovr_fetch_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       GROUP_BYTES = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fast_vld,
    input  logic              fast_taken,
    input  logic [ADDR_W-1:0] fast_target,
    input  logic              slow_vld,
    input  logic              slow_taken,
    input  logic [ADDR_W-1:0] slow_target,
    input  logic              rdr_vld,
    input  logic [ADDR_W-1:0] rdr_target,
    input  logic              fq_full,
    output logic              fq_push,
    output logic [ADDR_W-1:0] fq_addr,
    output logic              fq_taken,
    output logic [ADDR_W-1:0] fq_next,
    output logic              ovr_flush,
    output logic [2:0]        kill_mask
);
    localparam logic [ADDR_W-1:0] GRP_INC = ADDR_W'(GROUP_BYTES);

    logic              fast_tk_eff;
    logic              s3_vld;
    logic [ADDR_W-1:0] s3_addr;
    logic              s3_tk;
    logic [ADDR_W-1:0] s3_tgt;
    logic              stall;
    logic              mismatch;
    logic              override;
    logic              pipe_flush;
    redir_e            redir;
    logic              fin_tk;
    logic [ADDR_W-1:0] fin_tgt;

    // An absent quick prediction means sequential fetch.
    assign fast_tk_eff = fast_vld & fast_taken;

    // Full queue freezes the front end only when stage 3 has a group to place.
    assign stall = fq_full & s3_vld;

    ovr_grp_pipe #(.ADDR_W(ADDR_W), .DEPTH(NUM_STAGES - 1)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (pipe_flush),
        .stall      (stall),
        .in_addr    (fetch_addr),
        .in_taken   (fast_tk_eff),
        .in_target  (fast_target),
        .out_vld    (s3_vld),
        .out_addr   (s3_addr),
        .out_taken  (s3_tk),
        .out_target (s3_tgt)
    );

    ovr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .fast_taken  (s3_tk),
        .fast_target (s3_tgt),
        .slow_taken  (slow_taken),
        .slow_target (slow_target),
        .mismatch    (mismatch)
    );

    // Override fires once, when a valid group leaves stage 3 unopposed.
    assign override = s3_vld & ~stall & slow_vld & mismatch & ~rdr_vld;

    // Redirect source selection; resolution beats override.
    always_comb begin
        if (rdr_vld)       redir = RD_EXTERNAL;
        else if (override) redir = RD_OVERRIDE;
        else               redir = RD_NONE;
    end

    assign pipe_flush = (redir != RD_NONE);

    // Final prediction of the stage-3 group and the address after it.
    always_comb begin
        fin_tk  = override ? slow_taken  : s3_tk;
        fin_tgt = override ? slow_target : s3_tgt;
        fq_next = fin_tk ? fin_tgt : s3_addr + GRP_INC;
    end

    ovr_pc_gen #(
        .ADDR_W      (ADDR_W),
        .GROUP_BYTES (GROUP_BYTES),
        .RESET_ADDR  (RESET_ADDR)
    ) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .redir       (redir),
        .stall       (stall),
        .ext_target  (rdr_target),
        .ovr_target  (fq_next),
        .fast_taken  (fast_tk_eff),
        .fast_target (fast_target),
        .pc          (fetch_addr)
    );

    // Queue write and flush reporting.
    always_comb begin
        fq_push   = s3_vld & ~stall & ~rdr_vld;
        fq_addr   = s3_addr;
        fq_taken  = fin_tk;
        ovr_flush = override;
        unique case (redir)
            RD_EXTERNAL: kill_mask = KILL_ALL;
            RD_OVERRIDE: kill_mask = KILL_YOUNG;
            default:     kill_mask = KILL_NONE;
        endcase
    end

    // R8: never write into a full queue.
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        fq_push |-> !fq_full)
        else $error("a_r8_no_push_full");
    // R8: fetch address holds across a stall cycle without redirect.
    a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fq_full && s3_vld && !rdr_vld) |=> $stable(fetch_addr))
        else $error("a_r8_pc_hold");
    // R5: an override always places its own group and restarts after it.
    a_r5_ovr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flush |-> fq_push ##1 (fetch_addr == $past(fq_next)))
        else $error("a_r5_ovr_restart");
    // R7: a resolution redirect suppresses queue writes and overrides.
    a_r7_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rdr_vld |-> !fq_push && !ovr_flush)
        else $error("a_r7_ext_quiet");
    // R5: after an override the next cycle has nothing left in stage 3.
    a_r5_no_young_push: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flush |=> !fq_push)
        else $error("a_r5_no_young_push");
endmodule

// File: tb/sim_ovr_fetch_ctrl.sv
`timescale 1ns/1ps
module sim_ovr_fetch_ctrl;
    localparam int unsigned AW = 16;
    localparam int unsigned NV = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_addr;
    logic          fast_vld = 1'b0, fast_taken = 1'b0;
    logic [AW-1:0] fast_target = '0;
    logic          slow_vld = 1'b0, slow_taken = 1'b0;
    logic [AW-1:0] slow_target = '0;
    logic          rdr_vld = 1'b0;
    logic [AW-1:0] rdr_target = '0;
    logic          fq_full = 1'b0;
    logic          fq_push, fq_taken, ovr_flush;
    logic [AW-1:0] fq_addr, fq_next;
    logic [2:0]    kill_mask;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ovr_fetch_ctrl #(.ADDR_W(AW), .GROUP_BYTES(16), .RESET_ADDR(16'h0100)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
        .fast_vld(fast_vld), .fast_taken(fast_taken), .fast_target(fast_target),
        .slow_vld(slow_vld), .slow_taken(slow_taken), .slow_target(slow_target),
        .rdr_vld(rdr_vld), .rdr_target(rdr_target), .fq_full(fq_full),
        .fq_push(fq_push), .fq_addr(fq_addr), .fq_taken(fq_taken),
        .fq_next(fq_next), .ovr_flush(ovr_flush), .kill_mask(kill_mask)
    );

    typedef struct packed {
        logic          fv; logic ft; logic [AW-1:0] ftg;
        logic          sv; logic st; logic [AW-1:0] stg;
        logic          rv; logic [AW-1:0] rtg;
        logic          full;
        logic [AW-1:0] e_pc;
        logic          e_push; logic [AW-1:0] e_addr; logic e_tk; logic [AW-1:0] e_next;
        logic          e_ovr; logic [2:0] e_kill;
        logic [3:0]    rq;
    } vec_t;

    // One row per cycle: inputs, then expected outputs in that cycle.
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 16'h0100, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b000, 4'd2},
        '{1'b1,1'b1,16'h0200, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 16'h0110, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b000, 4'd2},
        '{1'b1,1'b0,16'h0000, 1'b1,1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 16'h0200, 1'b1,16'h0100,1'b0,16'h0110, 1'b0,3'b000, 4'd4},
        '{1'b0,1'b0,16'h0000, 1'b1,1'b1,16'h0200, 1'b0,16'h0000, 1'b0, 16'h0210, 1'b1,16'h0110,1'b1,16'h0200, 1'b0,3'b000, 4'd3},
        '{1'b1,1'b0,16'h0000, 1'b1,1'b1,16'h0300, 1'b0,16'h0000, 1'b0, 16'h0220, 1'b1,16'h0200,1'b1,16'h0300, 1'b1,3'b011, 4'd5},
        '{1'b1,1'b1,16'h0400, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 16'h0300, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b000, 4'd5},
        '{1'b1,1'b0,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 16'h0400, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b000, 4'd5},
        '{1'b1,1'b0,16'h0000, 1'b1,1'b1,16'h0500, 1'b0,16'h0000, 1'b0, 16'h0410, 1'b1,16'h0300,1'b1,16'h0500, 1'b1,3'b011, 4'd6},
        '{1'b1,1'b0,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 16'h0500, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b000, 4'd2},
        '{1'b1,1'b1,16'h0600, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 16'h0510, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b000, 4'd2},
        '{1'b1,1'b0,16'h0777, 1'b1,1'b0,16'h0999, 1'b0,16'h0000, 1'b0, 16'h0600, 1'b1,16'h0500,1'b0,16'h0510, 1'b0,3'b000, 4'd6},
        '{1'b1,1'b1,16'h0800, 1'b1,1'b0,16'h0000, 1'b0,16'h0000, 1'b1, 16'h0610, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b000, 4'd8},
        '{1'b1,1'b1,16'h0800, 1'b1,1'b0,16'h0000, 1'b0,16'h0000, 1'b1, 16'h0610, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b000, 4'd8},
        '{1'b1,1'b0,16'h0000, 1'b1,1'b1,16'h0600, 1'b0,16'h0000, 1'b0, 16'h0610, 1'b1,16'h0510,1'b1,16'h0600, 1'b0,3'b000, 4'd8},
        '{1'b1,1'b0,16'h0000, 1'b1,1'b1,16'h0B00, 1'b1,16'h0A00, 1'b0, 16'h0620, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b111, 4'd7},
        '{1'b1,1'b0,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b1, 16'h0A00, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b000, 4'd9},
        '{1'b1,1'b0,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 16'h0A10, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b000, 4'd9},
        '{1'b1,1'b0,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 16'h0A20, 1'b1,16'h0A00,1'b0,16'h0A10, 1'b0,3'b000, 4'd4},
        '{1'b1,1'b0,16'h0000, 1'b1,1'b1,16'h0C00, 1'b0,16'h0000, 1'b0, 16'h0A30, 1'b1,16'h0A10,1'b1,16'h0C00, 1'b1,3'b011, 4'd5},
        '{1'b1,1'b0,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 16'h0C00, 1'b0,16'h0000,1'b0,16'h0000, 1'b0,3'b000, 4'd5}
    };

    function automatic string req_name(input logic [3:0] c);
        case (c)
            4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
            4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
            4'd7: return "R7";  4'd8: return "R8";  default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fast_vld = 1'b1; fast_taken = 1'b0; fast_target = '0;
        slow_vld = 1'b0; slow_taken = 1'b0; slow_target = '0;
        rdr_vld = 1'b0; rdr_target = '0; fq_full = 1'b0;
    endtask

    task automatic run_row(input vec_t v, input int idx);
        string rq;
        rq = $sformatf("%s row %0d", req_name(v.rq), idx);
        fast_vld = v.fv; fast_taken = v.ft; fast_target = v.ftg;
        slow_vld = v.sv; slow_taken = v.st; slow_target = v.stg;
        rdr_vld = v.rv; rdr_target = v.rtg; fq_full = v.full;
        #1;
        chk(fetch_addr == v.e_pc, rq, "fetch_addr", fetch_addr, v.e_pc);
        chk(fq_push == v.e_push, rq, "fq_push", AW'(fq_push), AW'(v.e_push));
        chk(ovr_flush == v.e_ovr, rq, "ovr_flush", AW'(ovr_flush), AW'(v.e_ovr));
        chk(kill_mask == v.e_kill, rq, "kill_mask", AW'(kill_mask), AW'(v.e_kill));
        if (v.e_push) begin
            chk(fq_addr == v.e_addr, rq, "fq_addr", fq_addr, v.e_addr);
            chk(fq_taken == v.e_tk, rq, "fq_taken", AW'(fq_taken), AW'(v.e_tk));
            chk(fq_next == v.e_next, rq, "fq_next", fq_next, v.e_next);
        end
        @(negedge clk);
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is held.
        #1;
        chk(fetch_addr == 16'h0100, "R1", "fetch_addr in reset", fetch_addr, 16'h0100);
        chk(!fq_push, "R1", "fq_push in reset", AW'(fq_push), 16'h0000);
        chk(kill_mask == 3'b000, "R1", "kill_mask in reset", AW'(kill_mask), 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        // Wait: the release edge above already passed; re-arm a clean reset.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_row(VEC[i], i);

        // R1: reset in mid-run discards in-flight groups.
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(fetch_addr == 16'h0100, "R1", "fetch_addr after mid-run reset", fetch_addr, 16'h0100);
        chk(!fq_push, "R1", "fq_push after mid-run reset", AW'(fq_push), 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R2: first fetch after reset steps sequentially.
        chk(fetch_addr == 16'h0110, "R2", "fetch_addr after release", fetch_addr, 16'h0110);
        chk(!fq_push && kill_mask == 3'b000, "R1", "quiet after release",
            AW'({fq_push, kill_mask}), 16'h0000);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule